// File: doc/BRIEF.md
# T1/E1 Bipolar Line Encoder

This block sits on the transmit side of a T1/E1 line interface. Each cycle of the transmit clock it takes one bit of system data and turns it into two line-driver strobes, one for each polarity of a balanced bipolar signal. A positive mark drives the tip strobe and a negative mark drives the ring strobe. A data zero drives neither. Each strobe lasts one bit period. The analog shaping and equalization downstream are outside this block.

The input can be single-rail NRZ data. In that case the encoder makes the marks alternate in polarity, and it can replace long zero runs with a substitution code: B8ZS for the 1.544 MHz rate or HDB3 for the 2.048 MHz rate. The input can also be dual-rail, with positive and negative NRZ rails already split. In that case the rails pass straight to the strobes through a fixed pipeline. Each configuration has its own fixed latency. A lookahead shift register, long enough for the selected code, gives the encoder time to see a whole zero run before the first bit of that run reaches the line.

Top module: `bipolar_line_encoder`

## Requirements
- R1: While `rst` is high at a clock edge, both strobes are low after that edge. Reset sets the remembered polarity to negative, so the first mark after reset drives `line_tip`.
- R2: In AMI mode (single-rail, `code_sel` = 2'b00), every input one produces a single strobe and every input zero produces none. Successive marks alternate between `line_tip` and `line_ring`.
- R3: `line_tip` and `line_ring` are never high in the same bit period.
- R4: The latency from the clock edge that samples an input bit to the clock edge that drives its strobe is fixed for each configuration: 3 cycles in AMI and in dual-rail mode, 4 cycles in HDB3 mode, and 8 cycles in B8ZS mode.
- R5: In B8ZS mode (single-rail, `code_sel` = 2'b01), each run of eight zeros is sent as 000VB0VB in time order. V repeats the polarity of the mark before it. B takes the polarity opposite to the mark before it.
- R6: In HDB3 mode (single-rail, `code_sel` = 2'b10), each run of four zeros is sent as 000V when the number of marks since the last V is odd, and as B00V when that number is even. A B counts as a mark. The count is even after reset.
- R7: Once the output comes from substituted data, no more than 3 consecutive empty bit periods occur in HDB3 mode, and no more than 7 in B8ZS mode.
- R8: In dual-rail mode (`dual_rail` = 1), `tx_pos` alone drives `line_tip` and `tx_neg` alone drives `line_ring`. Both rails high, or both low, give no strobe. No alternation or substitution is applied, and `code_sel` has no effect.
- R9: The `code_sel` value 2'b11 behaves exactly like AMI mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_rail | input | 1 | 0: single-rail input on `tx_data`; 1: dual-rail input on `tx_pos`/`tx_neg` |
| code_sel | input | 2 | 00 AMI, 01 B8ZS, 10 HDB3, 11 AMI |
| tx_data | input | 1 | Single-rail NRZ data |
| tx_pos | input | 1 | Dual-rail positive NRZ data |
| tx_neg | input | 1 | Dual-rail negative NRZ data |
| line_tip | output | 1 | Positive-mark driver strobe |
| line_ring | output | 1 | Negative-mark driver strobe |

## Verification
The checker assumes that `dual_rail` and `code_sel` only change while `rst` is high. The shift register is shared by all modes, so a change of mode during operation would read the wrong tap. The checks on latency, alternation and zero runs count bit periods from the release of reset on that basis. The bench sets the configuration pins only while reset is held, then drives a stream of random or directed data for each configuration. It compares every strobe against a bit-serial model of the substitution codes.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

    // Symbol carried down the lookahead window
    typedef enum logic [2:0] {
        SYM_ZERO = 3'd0,   // empty bit period
        SYM_MARK = 3'd1,   // data one, alternating polarity
        SYM_BAL  = 3'd2,   // substituted balancing mark, alternating
        SYM_VIOL = 3'd3,   // substituted violation, repeats polarity
        SYM_FPOS = 3'd4,   // dual-rail forced positive
        SYM_FNEG = 3'd5    // dual-rail forced negative
    } sym_t;

    typedef enum logic [1:0] {
        MODE_AMI  = 2'd0,
        MODE_B8ZS = 2'd1,
        MODE_HDB3 = 2'd2,
        MODE_DUAL = 2'd3
    } mode_t;

    typedef struct packed {
        logic tip;
        logic ring;
    } rails_t;

    localparam int B8ZS_RUN = 8;
    localparam int HDB3_RUN = 4;

    function automatic mode_t decode_mode(input logic dual, input logic [1:0] code);
        if (dual)
            return MODE_DUAL;
        case (code)
            2'b01:   return MODE_B8ZS;
            2'b10:   return MODE_HDB3;
            default: return MODE_AMI;
        endcase
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic alternates(input sym_t s);
        return (s == SYM_MARK) || (s == SYM_BAL);
    endfunction

endpackage

// File: rtl/lenc_sym_map.sv
module lenc_sym_map
    import lenc_pkg::*;
(
    input  mode_t mode,
    input  logic  data,
    input  logic  pos,
    input  logic  neg,
    output sym_t  sym
);
    always_comb begin
        if (mode == MODE_DUAL) begin
            if (pos && !neg)
                sym = SYM_FPOS;
            else if (neg && !pos)
                sym = SYM_FNEG;
            else
                sym = SYM_ZERO;
        end else begin
            sym = data ? SYM_MARK : SYM_ZERO;
        end
    end
endmodule

// File: rtl/lenc_window.sv
module lenc_window
    import lenc_pkg::*;
#(
    parameter int LAT_AMI  = 3,
    parameter int LAT_HDB3 = 4,
    parameter int LAT_B8ZS = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  mode_t mode,
    input  sym_t  sym_in,
    input  logic  odd_next,   // mark parity after the exiting symbol
    output sym_t  exit_sym
);
    localparam int DEPTH = max3(LAT_AMI, LAT_HDB3, LAT_B8ZS);
    localparam int E_AMI = LAT_AMI - 1;
    localparam int E_H3  = LAT_HDB3 - 1;
    localparam int E_B8  = LAT_B8ZS - 1;

    sym_t sr      [DEPTH];
    sym_t shifted [DEPTH];
    sym_t nxt     [DEPTH];
    logic b8_zero;
    logic h3_zero;

    assign shifted[0] = sym_in;
    for (genvar k = 1; k < DEPTH; k++) begin : g_shift
        assign shifted[k] = sr[k-1];
    end

    // Zero runs whose oldest bit is next to leave the window
    always_comb begin
        b8_zero = 1'b1;
        for (int k = E_B8 - (B8ZS_RUN - 1); k <= E_B8; k++)
            if (shifted[k] != SYM_ZERO)
                b8_zero = 1'b0;
        h3_zero = 1'b1;
        for (int k = E_H3 - (HDB3_RUN - 1); k <= E_H3; k++)
            if (shifted[k] != SYM_ZERO)
                h3_zero = 1'b0;
    end

    always_comb begin
        for (int k = 0; k < DEPTH; k++)
            nxt[k] = shifted[k];
        if (mode == MODE_B8ZS && b8_zero) begin
            // time order from slot E_B8 downwards: 0 0 0 V B 0 V B
            nxt[E_B8-3] = SYM_VIOL;
            nxt[E_B8-4] = SYM_BAL;
            nxt[E_B8-6] = SYM_VIOL;
            nxt[E_B8-7] = SYM_BAL;
        end else if (mode == MODE_HDB3 && h3_zero) begin
            nxt[E_H3-3] = SYM_VIOL;
            if (!odd_next)
                nxt[E_H3] = SYM_BAL;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++)
                sr[k] <= SYM_ZERO;
        end else begin
            for (int k = 0; k < DEPTH; k++)
                sr[k] <= nxt[k];
        end
    end

    always_comb begin
        case (mode)
            MODE_B8ZS: exit_sym = sr[E_B8];
            MODE_HDB3: exit_sym = sr[E_H3];
            default:   exit_sym = sr[E_AMI];
        endcase
    end
endmodule

// File: rtl/lenc_polarity.sv
module lenc_polarity
    import lenc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sym_t   sym,
    output rails_t rails,
    output logic   odd_next
);
    logic   last_pos;     // polarity of the previous mark, 1 = positive
    logic   odd;          // marks since last violation is odd
    logic   last_pos_n;
    rails_t rails_n;

    always_comb begin
        rails_n    = '0;
        last_pos_n = last_pos;
        odd_next   = odd;
        if (alternates(sym)) begin
            rails_n.tip  = ~last_pos;
            rails_n.ring = last_pos;
            last_pos_n   = ~last_pos;
            odd_next     = ~odd;
        end else begin
            case (sym)
                SYM_VIOL: begin
                    rails_n.tip  = last_pos;
                    rails_n.ring = ~last_pos;
                    odd_next     = 1'b0;
                end
                SYM_FPOS: rails_n.tip  = 1'b1;
                SYM_FNEG: rails_n.ring = 1'b1;
                default:  rails_n = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rails    <= '0;
            last_pos <= 1'b0;
            odd      <= 1'b0;
        end else begin
            rails    <= rails_n;
            last_pos <= last_pos_n;
            odd      <= odd_next;
        end
    end
endmodule

// File: rtl/bipolar_line_encoder.sv
module bipolar_line_encoder
    import lenc_pkg::*;
#(
    parameter int LAT_AMI  = 3,
    parameter int LAT_HDB3 = 4,
    parameter int LAT_B8ZS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dual_rail,
    input  logic [1:0] code_sel,
    input  logic       tx_data,
    input  logic       tx_pos,
    input  logic       tx_neg,
    output logic       line_tip,
    output logic       line_ring
);
    mode_t  mode;
    sym_t   in_sym;
    sym_t   exit_sym;
    logic   odd_next;
    rails_t rails;

    assign mode = decode_mode(dual_rail, code_sel);

    lenc_sym_map u_map (
        .mode (mode),
        .data (tx_data),
        .pos  (tx_pos),
        .neg  (tx_neg),
        .sym  (in_sym)
    );

    lenc_window #(
        .LAT_AMI  (LAT_AMI),
        .LAT_HDB3 (LAT_HDB3),
        .LAT_B8ZS (LAT_B8ZS)
    ) u_win (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .sym_in   (in_sym),
        .odd_next (odd_next),
        .exit_sym (exit_sym)
    );

    lenc_polarity u_pol (
        .clk      (clk),
        .rst      (rst),
        .sym      (exit_sym),
        .rails    (rails),
        .odd_next (odd_next)
    );

    assign line_tip  = rails.tip;
    assign line_ring = rails.ring;
endmodule

// File: rtl/lenc_chk.sv
module lenc_chk #(
    parameter int LAT_AMI = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       dual_rail,
    input logic [1:0] code_sel,
    input logic       tx_data,
    input logic       tx_pos,
    input logic       tx_neg,
    input logic       line_tip,
    input logic       line_ring
);
    logic [15:0] d_h, p_h, n_h;
    logic [4:0]  cyc;
    logic [3:0]  zrun;
    logic        prev_tip;
    logic        ami, sub_b8, sub_h3, pulse;

    assign ami    = !dual_rail && (code_sel == 2'b00 || code_sel == 2'b11);
    assign sub_b8 = !dual_rail && code_sel == 2'b01;
    assign sub_h3 = !dual_rail && code_sel == 2'b10;
    assign pulse  = line_tip || line_ring;

    always_ff @(posedge clk) begin
        if (rst) begin
            d_h      <= '0;
            p_h      <= '0;
            n_h      <= '0;
            cyc      <= '0;
            zrun     <= '0;
            prev_tip <= 1'b0;
        end else begin
            d_h <= {d_h[14:0], tx_data};
            p_h <= {p_h[14:0], tx_pos};
            n_h <= {n_h[14:0], tx_neg};
            if (cyc != 5'd31)
                cyc <= cyc + 5'd1;
            if (pulse)
                zrun <= '0;
            else if (cyc >= 5'd2 && zrun != 4'd15)
                zrun <= zrun + 4'd1;
            if (pulse)
                prev_tip <= line_tip;
        end
    end

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!line_tip && !line_ring));

    // R3
    a_r3_one_rail: assert property (@(posedge clk) disable iff (rst)
        !(line_tip && line_ring));

    // R2: marks alternate, starting positive
    a_r2_alternate: assert property (@(posedge clk) disable iff (rst)
        (ami && pulse) |-> (line_tip != prev_tip));

    // R4: AMI strobe follows the data sampled LAT_AMI edges earlier
    a_r4_ami_latency: assert property (@(posedge clk) disable iff (rst)
        (ami && cyc >= 5'(LAT_AMI + 1)) |-> (pulse == d_h[LAT_AMI]));

    // R8
    a_r8_dual_pass: assert property (@(posedge clk) disable iff (rst)
        (dual_rail && cyc >= 5'(LAT_AMI + 1)) |->
            (line_tip == (p_h[LAT_AMI] && !n_h[LAT_AMI]) &&
             line_ring == (n_h[LAT_AMI] && !p_h[LAT_AMI])));

    // R7
    a_r7_zero_bound: assert property (@(posedge clk) disable iff (rst)
        ((sub_b8 || sub_h3) && cyc >= 5'd2 && !pulse) |->
            (zrun < (sub_b8 ? 4'd7 : 4'd3)));
endmodule

bind bipolar_line_encoder lenc_chk #(.LAT_AMI(LAT_AMI)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dual_rail (dual_rail),
    .code_sel  (code_sel),
    .tx_data   (tx_data),
    .tx_pos    (tx_pos),
    .tx_neg    (tx_neg),
    .line_tip  (line_tip),
    .line_ring (line_ring)
);

// File: tb/tb_bipolar_line_encoder.sv
module tb_bipolar_line_encoder;

    localparam int T  = 160;
    localparam int SZ = T + 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dual_rail = 1'b0;
    logic [1:0] code_sel = 2'b00;
    logic       tx_data = 1'b0;
    logic       tx_pos = 1'b0;
    logic       tx_neg = 1'b0;
    logic       line_tip;
    logic       line_ring;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit rd [SZ];
    bit rp [SZ];
    bit rn [SZ];
    int sy [SZ];        // 0 zero,1 mark,2 bal,3 viol,4 fpos,5 fneg
    bit et [SZ];
    bit er [SZ];

    bipolar_line_encoder dut (
        .clk (clk), .rst (rst), .dual_rail (dual_rail), .code_sel (code_sel),
        .tx_data (tx_data), .tx_pos (tx_pos), .tx_neg (tx_neg),
        .line_tip (line_tip), .line_ring (line_ring)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Bit-serial model of the line code over the padded stream
    task automatic build_model(input bit dual, input bit sb8, input bit sh3, input int len);
        int  i, nrun;
        bit  odd, last, allz;
        odd  = 0;
        nrun = sb8 ? 8 : 4;
        i    = 0;
        while (i < len) begin
            if (dual) begin
                sy[i] = (rp[i] && !rn[i]) ? 4 : ((rn[i] && !rp[i]) ? 5 : 0);
                i++;
            end else begin
                allz = (sb8 || sh3) && (i + nrun <= len);
                if (allz)
                    for (int k = 0; k < nrun; k++)
                        if (rd[i+k]) allz = 0;
                if (allz && sb8) begin
                    sy[i] = 0; sy[i+1] = 0; sy[i+2] = 0; sy[i+3] = 3;
                    sy[i+4] = 2; sy[i+5] = 0; sy[i+6] = 3; sy[i+7] = 2;
                    odd = 0;
                    i += 8;
                end else if (allz) begin
                    sy[i] = odd ? 0 : 2; sy[i+1] = 0; sy[i+2] = 0; sy[i+3] = 3;
                    odd = 0;
                    i += 4;
                end else begin
                    sy[i] = rd[i] ? 1 : 0;
                    if (rd[i]) odd = !odd;
                    i++;
                end
            end
        end
        last = 0;
        for (int j = 0; j < len; j++) begin
            et[j] = 0; er[j] = 0;
            case (sy[j])
                1, 2: begin et[j] = !last; er[j] = last; last = !last; end
                3:    begin et[j] = last;  er[j] = !last; end
                4:    et[j] = 1;
                5:    er[j] = 1;
                default: ;
            endcase
        end
    endtask

    // kind: 0 random (pct % ones), 1 all zeros, 2 all ones
    task automatic run_case(input bit dual, input bit [1:0] code, input int kind,
                            input int pct, input string tag);
        int lat, e, len, first_m, zrun, zmax, last_m;
        bit sb8, sh3, both, got_t, got_r;
        sb8 = !dual && code == 2'b01;
        sh3 = !dual && code == 2'b10;
        lat = sb8 ? 8 : (sh3 ? 4 : 3);
        e   = lat - 1;
        len = e + T;
        for (int i = 0; i < len; i++) begin
            if (i < e) begin
                rd[i] = 0; rp[i] = 0; rn[i] = 0;
            end else if (kind == 1) begin
                rd[i] = 0; rp[i] = 0; rn[i] = 0;
            end else if (kind == 2) begin
                rd[i] = 1; rp[i] = 1; rn[i] = 0;
            end else begin
                rd[i] = ($urandom % 100) < pct;
                rp[i] = ($urandom % 100) < pct;
                rn[i] = ($urandom % 100) < pct;
            end
        end
        build_model(dual, sb8, sh3, len);

        @(negedge clk);
        rst = 1; dual_rail = dual; code_sel = code;
        tx_data = 0; tx_pos = 0; tx_neg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!line_tip && !line_ring, "R1", {tag, " reset strobes"},
              {line_tip, line_ring}, 0);
        rst = 0;
        tx_data = rd[e]; tx_pos = rp[e]; tx_neg = rn[e];

        first_m = -1; first_t_ok = 1; zrun = 0; zmax = 0; both = 0;
        last_m = len - 8 + 1;
        for (int m = 1; m <= last_m; m++) begin
            @(posedge clk);
            @(negedge clk);
            got_t = line_tip; got_r = line_ring;
            if (got_t && got_r) both = 1;
            if (m >= 2) begin
                check(got_t == et[m-2] && got_r == er[m-2], tag,
                      $sformatf("strobes at period %0d", m - 2),
                      {got_t, got_r}, {et[m-2], er[m-2]});
                if (got_t || got_r) zrun = 0;
                else begin
                    zrun++;
                    if (zrun > zmax) zmax = zrun;
                end
            end
            if ((got_t || got_r) && first_m < 0) begin
                first_m = m;
                first_tip = got_t;
            end
            if (e + m < len) begin
                tx_data = rd[e+m]; tx_pos = rp[e+m]; tx_neg = rn[e+m];
            end else begin
                tx_data = 0; tx_pos = 0; tx_neg = 0;
            end
        end
        check(!both, "R3", {tag, " both strobes seen"}, both, 0);
        if (sb8 || sh3)
            check(zmax <= (sb8 ? 7 : 3), "R7", {tag, " longest empty run"},
                  zmax, sb8 ? 7 : 3);
        if (kind == 2) begin
            check(first_m == lat + 1, "R4", {tag, " first strobe edge"}, first_m, lat + 1);
            check(first_tip, "R1", {tag, " first mark positive"}, first_tip, 1);
        end
    endtask

    bit first_tip;
    bit first_t_ok;

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        run_case(0, 2'b00, 0, 50, "R2");
        run_case(0, 2'b00, 2, 0,  "R2/R4");
        run_case(0, 2'b01, 0, 30, "R5");
        run_case(0, 2'b01, 0, 10, "R5");
        run_case(0, 2'b01, 1, 0,  "R5");
        run_case(0, 2'b01, 2, 0,  "R5/R4");
        run_case(0, 2'b10, 0, 30, "R6");
        run_case(0, 2'b10, 0, 10, "R6");
        run_case(0, 2'b10, 1, 0,  "R6");
        run_case(0, 2'b10, 2, 0,  "R6/R4");
        run_case(0, 2'b11, 0, 50, "R9");
        run_case(1, 2'b00, 0, 40, "R8");
        run_case(1, 2'b01, 0, 40, "R8");
        run_case(1, 2'b10, 2, 0,  "R8/R4");
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule